// File: doc/BRIEF.md
# PHY Management Register File

This block models the management side of an Ethernet PHY as seen by a host. The PHY is never reached directly. The host first loads a target word that names a PHY address and a register number. Then it either writes a data word, which is a management write to that register, or reads one, which is a management read. The block holds four registers: a control word, a status word, an advertisement word and a link-partner ability word. It also returns two fixed identifier words.

A `link_up` input drives the link-status and negotiation-complete bits and the partner ability word. No negotiation takes place. A soft reset through the control word reloads every writable register and picks up the present link level.

Requests enter on a valid/ready channel. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. Each read returns exactly one response on a second valid/ready channel. That response holds its data until `rsp_ready` takes it. While a response is waiting, `req_ready` stays low, so at most one read is in flight. Writes produce no response.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, the registers hold these values. Control reads 0x3100 (bit 13 speed 100, bit 12 autonegotiation enable, bit 8 full duplex). Status reads 0x7848. Advertisement reads 0x01E1. Partner ability reads 0x0080. The target word reads 0x0000.
- R2: The request channel behaves as follows.
  - `req_ready` is low whenever a response is pending.
  - `rsp_valid` rises on the edge that accepts a read.
  - `rsp_valid` stays high with `rsp_rdata` unchanged until it is taken with `rsp_ready`.
  - Writes never produce a response.
- R3: `req_sel`=0 addresses the target word and `req_sel`=1 addresses the data word.
  - The target word holds the PHY address in bits 15:8 and the register number in bits 7:0.
  - A read with `req_sel`=0 returns the stored target word.
- R4: The PHY address field is compared against the `PHY_ADDR` parameter, a 5-bit value that defaults to 0.
  - When they differ, a data read returns 0xFFFF.
  - When they differ, a data write changes nothing.
- R5: While `link_up` is high, status bits 2 (link) and 5 (negotiation complete) are set, giving status 0x786C. Partner ability reads 0x01E0 (bits 8, 7, 6, 5).
- R6: While `link_up` is low, status bits 2 and 5 are clear (0x7848) and partner ability reads 0x0080.
- R7: Register 0 (control) and register 4 (advertisement) are writable.
  - A data write with bit 15 clear stores the word.
  - Any later read returns the stored word.
- R8: A data write to register 0 with bit 15 set restores control to 0x3100 and advertisement to 0x01E1. Status and partner ability then follow the current `link_up`.
- R9: Data writes to register 1 (status), registers 2 and 3 (identifiers) and register 5 (partner ability) are ignored.
- R10: Register 2 returns the `ID_HI` parameter and register 3 returns the `ID_LO` parameter.
- R11: Register numbers 6 to 255 read as 0x0000, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up | input | 1 | Link level that forces the status and partner bits |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 1 | 0 = target word, 1 = data word |
| req_wdata | input | 16 | Write value |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 16 | Read response value |

## Verification
- **Read responses:** read data is captured on the edge that accepts the read. It is therefore compared at the falling edge right after that acceptance. It is compared again on every falling edge while `rsp_ready` is held low for a random number of cycles.
- **Writes:** a write takes effect on its accepting edge. Every later read reflects it.
- **Link changes:** a change on `link_up` is sampled by the next rising edge. The bench drives the link at a falling edge and lets one full cycle pass before issuing any request.
- **Expected values:** they come from a bench model updated at the moment each write is accepted.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int DATA_W  = 16;
  localparam int FIELD_W = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regno;
  } mgmt_target_t;

  localparam logic [FIELD_W-1:0] RN_CTRL    = 8'd0;
  localparam logic [FIELD_W-1:0] RN_STAT    = 8'd1;
  localparam logic [FIELD_W-1:0] RN_ID_HI   = 8'd2;
  localparam logic [FIELD_W-1:0] RN_ID_LO   = 8'd3;
  localparam logic [FIELD_W-1:0] RN_ADV     = 8'd4;
  localparam logic [FIELD_W-1:0] RN_PARTNER = 8'd5;

  // control word fields
  localparam int CB_SOFT_RST = 15;
  localparam int CB_SPEED100 = 13;
  localparam int CB_AN_EN    = 12;
  localparam int CB_FULL_DPX = 8;

  // status word fields
  localparam int SB_100_FD  = 14;
  localparam int SB_100_HD  = 13;
  localparam int SB_10_FD   = 12;
  localparam int SB_10_HD   = 11;
  localparam int SB_PRE_SUP = 6;
  localparam int SB_AN_DONE = 5;
  localparam int SB_AN_ABLE = 3;
  localparam int SB_LINK    = 2;

  // ability word fields (advertisement and partner)
  localparam int AB_100_FD = 8;
  localparam int AB_100_HD = 7;
  localparam int AB_10_FD  = 6;
  localparam int AB_10_HD  = 5;
  localparam int AB_CSMA   = 0;

  function automatic logic [DATA_W-1:0] ctrl_default();
    logic [DATA_W-1:0] w;
    w = '0;
    w[CB_SPEED100] = 1'b1;
    w[CB_AN_EN]    = 1'b1;
    w[CB_FULL_DPX] = 1'b1;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] adv_default();
    logic [DATA_W-1:0] w;
    w = '0;
    w[AB_100_FD] = 1'b1;
    w[AB_100_HD] = 1'b1;
    w[AB_10_FD]  = 1'b1;
    w[AB_10_HD]  = 1'b1;
    w[AB_CSMA]   = 1'b1;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] stat_for(input logic up);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SB_100_FD]  = 1'b1;
    w[SB_100_HD]  = 1'b1;
    w[SB_10_FD]   = 1'b1;
    w[SB_10_HD]   = 1'b1;
    w[SB_PRE_SUP] = 1'b1;
    w[SB_AN_ABLE] = 1'b1;
    w[SB_AN_DONE] = up;
    w[SB_LINK]    = up;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] partner_for(input logic up);
    logic [DATA_W-1:0] w;
    w = '0;
    w[AB_100_HD] = 1'b1;
    w[AB_100_FD] = up;
    w[AB_10_FD]  = up;
    w[AB_10_HD]  = up;
    return w;
  endfunction

endpackage

// File: rtl/mgmt_host_port.sv
module mgmt_host_port
  import phy_mgmt_pkg::*;
#(
  parameter int                    PHY_ADDR_W = 5,
  parameter logic [PHY_ADDR_W-1:0] PHY_ADDR   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_sel,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [DATA_W-1:0] rd_value,
  output mgmt_target_t      tgt,
  output logic              addr_hit,
  output logic              mg_wr_en,
  output logic [DATA_W-1:0] mg_wdata
);

  localparam int PAD_W = FIELD_W - PHY_ADDR_W;
  localparam logic [FIELD_W-1:0] OWN_ADDR = {{PAD_W{1'b0}}, PHY_ADDR};

  logic accept;

  assign req_ready = !rsp_valid;
  assign accept    = req_valid && req_ready;
  assign addr_hit  = (tgt.phy == OWN_ADDR);
  assign mg_wr_en  = accept && req_write && req_sel && addr_hit;
  assign mg_wdata  = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (accept && req_write && !req_sel) begin
        tgt <= mgmt_target_t'(req_wdata);
      end
      if (accept && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= req_sel ? rd_value : DATA_W'(tgt);
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R2

  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && !req_write)); // R2

endmodule

// File: rtl/phy_reg_bank.sv
module phy_reg_bank
  import phy_mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_up,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_reg,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [DATA_W-1:0]  ctrl,
  output logic [DATA_W-1:0]  stat,
  output logic [DATA_W-1:0]  adv,
  output logic [DATA_W-1:0]  partner
);

  logic link_q;
  logic wr_ctrl, wr_adv, soft_rst;

  assign wr_ctrl  = wr_en && (wr_reg == RN_CTRL);
  assign wr_adv   = wr_en && (wr_reg == RN_ADV);
  assign soft_rst = wr_ctrl && wr_data[CB_SOFT_RST];

  assign stat    = stat_for(link_q);
  assign partner = partner_for(link_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= ctrl_default();
      adv    <= adv_default();
      link_q <= 1'b0;
    end else begin
      link_q <= link_up;
      if (soft_rst) begin
        ctrl <= ctrl_default();
        adv  <= adv_default();
      end else begin
        if (wr_ctrl) ctrl <= wr_data;
        if (wr_adv)  adv  <= wr_data;
      end
    end
  end

  AST_LINK_UP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |=> stat[SB_LINK] && stat[SB_AN_DONE] && partner == 16'h01E0); // R5

  AST_LINK_DOWN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |=> !stat[SB_LINK] && !stat[SB_AN_DONE] && partner == 16'h0080); // R6

  AST_SOFT_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_reg == 8'd0 && wr_data[15] |=> ctrl == 16'h3100 && adv == 16'h01E1); // R8

  AST_STATUS_CAPS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & 16'hFFDB) == 16'h7848); // R9

endmodule

// File: rtl/mgmt_read_mux.sv
module mgmt_read_mux
  import phy_mgmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_HI = 16'h0A1C,
  parameter logic [DATA_W-1:0] ID_LO = 16'h3E40
) (
  input  logic               addr_hit,
  input  logic [FIELD_W-1:0] regno,
  input  logic [DATA_W-1:0]  ctrl,
  input  logic [DATA_W-1:0]  stat,
  input  logic [DATA_W-1:0]  adv,
  input  logic [DATA_W-1:0]  partner,
  output logic [DATA_W-1:0]  rd_value
);

  logic [DATA_W-1:0] local_word;

  always_comb begin
    unique case (regno)
      RN_CTRL:    local_word = ctrl;
      RN_STAT:    local_word = stat;
      RN_ID_HI:   local_word = ID_HI;
      RN_ID_LO:   local_word = ID_LO;
      RN_ADV:     local_word = adv;
      RN_PARTNER: local_word = partner;
      default:    local_word = '0;
    endcase
  end

  assign rd_value = addr_hit ? local_word : '1;

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int                    PHY_ADDR_W = 5,
  parameter logic [PHY_ADDR_W-1:0] PHY_ADDR   = '0,
  parameter logic [15:0]           ID_HI      = 16'h0A1C,
  parameter logic [15:0]           ID_LO      = 16'h3E40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_up,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic        req_sel,
  input  logic [15:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [15:0] rsp_rdata
);

  mgmt_target_t      tgt;
  logic              addr_hit;
  logic              mg_wr_en;
  logic [DATA_W-1:0] mg_wdata;
  logic [DATA_W-1:0] rd_value;
  logic [DATA_W-1:0] ctrl, stat, adv, partner;

  mgmt_host_port #(.PHY_ADDR_W(PHY_ADDR_W), .PHY_ADDR(PHY_ADDR)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_sel   (req_sel),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rd_value  (rd_value),
    .tgt       (tgt),
    .addr_hit  (addr_hit),
    .mg_wr_en  (mg_wr_en),
    .mg_wdata  (mg_wdata)
  );

  phy_reg_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .wr_en   (mg_wr_en),
    .wr_reg  (tgt.regno),
    .wr_data (mg_wdata),
    .ctrl    (ctrl),
    .stat    (stat),
    .adv     (adv),
    .partner (partner)
  );

  mgmt_read_mux #(.ID_HI(ID_HI), .ID_LO(ID_LO)) u_mux (
    .addr_hit (addr_hit),
    .regno    (tgt.regno),
    .ctrl     (ctrl),
    .stat     (stat),
    .adv      (adv),
    .partner  (partner),
    .rd_value (rd_value)
  );

  AST_FOREIGN_READ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write && req_sel && !addr_hit |=> rsp_rdata == 16'hFFFF); // R4

endmodule

// File: tb/tb_phy_mgmt_regfile.sv
module tb_phy_mgmt_regfile;

  localparam logic [15:0] T_ID_HI = 16'h0A1C;
  localparam logic [15:0] T_ID_LO = 16'h3E40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic        req_sel = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [15:0] rsp_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] m_ctrl, m_adv, m_tgt;
  logic        m_link;

  always #5 clk = ~clk;

  phy_mgmt_regfile #(.ID_HI(T_ID_HI), .ID_LO(T_ID_LO)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  function automatic logic [15:0] exp_read(input logic [15:0] t);
    if (t[15:8] != 8'd0) return 16'hFFFF;
    case (t[7:0])
      8'd0: return m_ctrl;
      8'd1: return m_link ? 16'h786C : 16'h7848;
      8'd2: return T_ID_HI;
      8'd3: return T_ID_LO;
      8'd4: return m_adv;
      8'd5: return m_link ? 16'h01E0 : 16'h0080;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic do_req(input bit wr, input bit sel, input logic [15:0] d,
                        output logic [15:0] rd);
    rd = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_sel = sel; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      if (sel) begin
        if (m_tgt[15:8] == 8'd0) begin
          if (m_tgt[7:0] == 8'd0) begin
            if (d[15]) begin m_ctrl = 16'h3100; m_adv = 16'h01E1; end
            else m_ctrl = d;
          end else if (m_tgt[7:0] == 8'd4) begin
            m_adv = d;
          end
        end
      end else begin
        m_tgt = d;
      end
      chk("R2 no response after write", {15'd0, rsp_valid}, 16'd0);
    end else begin
      begin
        int w;
        w = $urandom_range(0, 3);
        chk("R2 response valid", {15'd0, rsp_valid}, 16'd1);
        rd = rsp_rdata;
        for (int i = 0; i < w; i++) begin
          @(negedge clk);
          chk("R2 response held", {15'd0, rsp_valid}, 16'd1);
          chk("R2 data stable", rsp_rdata, rd);
          chk("R2 ready low while pending", {15'd0, req_ready}, 16'd0);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R2 response consumed", {15'd0, rsp_valid}, 16'd0);
      end
    end
  endtask

  task automatic set_tgt(input logic [7:0] a, input logic [7:0] r);
    logic [15:0] dummy;
    do_req(1'b1, 1'b0, {a, r}, dummy);
  endtask

  task automatic mwrite(input logic [15:0] d);
    logic [15:0] dummy;
    do_req(1'b1, 1'b1, d, dummy);
  endtask

  task automatic mread(input string tag);
    logic [15:0] v;
    do_req(1'b0, 1'b1, 16'h0, v);
    chk(tag, v, exp_read(m_tgt));
  endtask

  task automatic set_link(input logic v);
    @(negedge clk);
    link_up = v;
    m_link = v;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    m_ctrl = 16'h3100; m_adv = 16'h01E1; m_tgt = 16'h0; m_link = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ready after reset", {15'd0, req_ready}, 16'd1);
    do_req(1'b0, 1'b0, 16'h0, v);
    chk("R1 target reset", v, 16'h0000);
    set_tgt(8'd0, 8'd0); mread("R1 control reset");
    chk("R1 control value", exp_read(m_tgt), 16'h3100);
    set_tgt(8'd0, 8'd1); mread("R1 status reset");
    set_tgt(8'd0, 8'd4); mread("R1 adv reset");
    set_tgt(8'd0, 8'd5); mread("R1 partner reset");

    // R10 identifiers
    set_tgt(8'd0, 8'd2); mread("R10 id hi");
    set_tgt(8'd0, 8'd3); mread("R10 id lo");

    // R5 / R6 link
    set_link(1'b1);
    set_tgt(8'd0, 8'd1); mread("R5 status link up");
    set_tgt(8'd0, 8'd5); mread("R5 partner link up");
    set_link(1'b0);
    set_tgt(8'd0, 8'd1); mread("R6 status link down");
    set_tgt(8'd0, 8'd5); mread("R6 partner link down");

    // R7 writable registers
    set_tgt(8'd0, 8'd0); mwrite(16'h1000); mread("R7 control stored");
    set_tgt(8'd0, 8'd4); mwrite(16'h0041); mread("R7 adv stored");

    // R9 read-only registers
    for (int r = 1; r <= 5; r++) begin
      if (r != 4) begin
        set_tgt(8'd0, 8'(r)); mwrite(16'hFFFF); mread("R9 read-only ignored");
      end
    end

    // R4 foreign address
    set_tgt(8'd3, 8'd0); mread("R4 foreign read");
    mwrite(16'h0000);
    set_tgt(8'd0, 8'd0); mread("R4 foreign write ignored");
    set_tgt(8'hFF, 8'd2); mread("R4 foreign id read");

    // R8 soft reset with link up
    set_link(1'b1);
    set_tgt(8'd0, 8'd0); mwrite(16'h8000); mread("R8 control defaults");
    set_tgt(8'd0, 8'd4); mread("R8 adv defaults");
    set_tgt(8'd0, 8'd1); mread("R8 status follows link");

    // R11 unimplemented registers
    set_tgt(8'd0, 8'd6); mwrite(16'hFFFF); mread("R11 reg 6 zero");
    set_tgt(8'd0, 8'd31); mread("R11 reg 31 zero");
    set_tgt(8'd0, 8'd200); mread("R11 reg 200 zero");

    // R3 target readback
    set_tgt(8'h12, 8'h34);
    do_req(1'b0, 1'b0, 16'h0, v);
    chk("R3 target readback", v, 16'h1234);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op <= 2) begin
        logic [7:0] a, r;
        a = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(1, 255)) : 8'd0;
        r = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 6));
        set_tgt(a, r);
      end else if (op <= 4) begin
        logic [15:0] d;
        d = 16'($urandom);
        if ($urandom_range(0, 3) != 0) d[15] = 1'b0;
        mwrite(d);
      end else if (op <= 7) begin
        mread("R7 random read");
      end else if (op == 8) begin
        do_req(1'b0, 1'b0, 16'h0, v);
        chk("R3 random target read", v, m_tgt);
      end else begin
        set_link(~m_link);
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule